// File: doc/BRIEF.md
# Bus Traffic Event Counter Unit

This block watches one on-chip bus port and counts what passes through it. It holds one cycle counter and four event counters. The monitored port gives it two single-cycle pulse inputs: one for a read data beat and one for a write data beat. Each event counter has its own select field, which picks read beats, write beats or both. From the cycle count and an event count, software can work out how busy the port is over a measurement window.

Software reaches the unit through a plain register port. A write strobe or a read strobe is held for one cycle, with a byte address and 32-bit data. Read data is registered and appears on the cycle after the read strobe. A typical session has these steps. Program the selects. Switch on counters through the set register. Write the control register with the run bit and both reset bits in one write. Let traffic flow. Clear the run bit to freeze everything. Then read the counts back as a consistent set. The fourth event counter is 40 bits wide and is read through two registers.

Top module: `bus_perf_monitor`

## Requirements
- R1: After reset the control register, the enable mask, every select register and every count read as zero.
- R2: The enable mask has five bits: bits 0 to 3 for event counters 0 to 3 and bit 4 for the cycle counter. A write to ENSET (0x04) ORs the data into the mask. A write to ENCLR (0x08) clears the mask bits where the data is 1. Zero bits leave the mask unchanged. A read of either address returns the mask.
- R3: The cycle counter (CYC, 0x20) advances by one on every clock edge at which the run bit and mask bit 4 were both set. It holds when either is clear.
- R4: Each event counter i has a select register at 0x10+4i. Select bit 0 counts read beats and bit 1 counts write beats. With both bits set, a cycle with both pulses adds 2. A counter moves only when the run bit and its mask bit are set.
- R5: While the run bit (CTRL bit 0) is clear, no counter changes, whatever pulses arrive.
- R6: The CTRL (0x00) event-reset bit (bit 1) and cycle-reset bit (bit 2) read back as 1 for exactly one cycle after the write and then clear themselves. On the next edge they zero all event counters, or the cycle counter, respectively. That zeroing wins over an increment in the same cycle and leaves the other counters untouched.
- R7: Event counters 0 to 2 read at 0x24, 0x28 and 0x2C. The 40-bit counter 3 reads its bits [7:0] at 0x30 and its bits [39:8] at 0x34, so its value is (high << 8) | low.
- R8: A read of an address outside the map returns zero, and a write to one changes no register.
- R9: The read data for a read strobe appears on the cycle after it and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Single-cycle register write strobe |
| reg_re | input | 1 | Single-cycle register read strobe |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| rd_beat | input | 1 | Pulse for each read data beat on the monitored port |
| wr_beat | input | 1 | Pulse for each write data beat on the monitored port |

## Verification
A wrong enable mask or select field shows up as a count that is off by a predictable amount at the next readback, once the unit has been frozen. Freezing makes every count an exact function of the number of enabled edges. A reset bit that stays set, or one that loses to an increment, shows on the very next control read, or as a count of one or two where zero is expected. A slip in the split of the wide counter moves the value between the two halves, so the test drives counter 3 past 255, where both halves are nonzero.

// File: rtl/bpm_pkg.sv
package bpm_pkg;
    localparam int NUM_EVT = 4;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 8;
    localparam int CNT_W   = 32;
    localparam int WIDE_W  = 40;
    localparam int LO_W    = 8;
    localparam int SEL_W   = 2;
    localparam int MASK_W  = NUM_EVT + 1;
    localparam int CYC_BIT = NUM_EVT;

    localparam logic [ADDR_W-1:0] A_CTRL     = 8'h00;
    localparam logic [ADDR_W-1:0] A_EN_SET   = 8'h04;
    localparam logic [ADDR_W-1:0] A_EN_CLR   = 8'h08;
    localparam logic [ADDR_W-1:0] A_SEL_BASE = 8'h10;
    localparam logic [ADDR_W-1:0] A_CYC      = 8'h20;
    localparam logic [ADDR_W-1:0] A_CNT_BASE = 8'h24;
    localparam logic [ADDR_W-1:0] A_WIDE_LO  = 8'h30;
    localparam logic [ADDR_W-1:0] A_WIDE_HI  = 8'h34;

    // Field order gives run at bit 0, event reset at bit 1, cycle reset at bit 2
    typedef struct packed {
        logic cyc_clr;
        logic evt_clr;
        logic run;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef logic [SEL_W-1:0] sel_t;

    // Per-cycle increment for one event counter: 0, 1 or 2
    function automatic logic [1:0] evt_step(sel_t sel, logic rd, logic wr);
        return {1'b0, sel[0] & rd} + {1'b0, sel[1] & wr};
    endfunction
endpackage

// File: rtl/bpm_counter.sv
module bpm_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         run,
    input  logic [1:0]   step,
    output logic [W-1:0] cnt
);
    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (run) begin
            cnt <= cnt + W'(step);
        end
    end

    AST_CLR_WINS: assert property (@(posedge clk) disable iff (rst)
        clr |=> cnt == '0); // R6

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (!clr && !run) |=> $stable(cnt)); // R5
endmodule

// File: rtl/bpm_regs.sv
module bpm_regs
    import bpm_pkg::*;
(
    input  logic                             clk,
    input  logic                             rst,
    input  logic                             reg_we,
    input  logic                             reg_re,
    input  logic [ADDR_W-1:0]                reg_addr,
    input  logic [DATA_W-1:0]                reg_wdata,
    output logic [DATA_W-1:0]                reg_rdata,
    output ctrl_t                            ctrl,
    output logic [MASK_W-1:0]                en_mask,
    output sel_t [NUM_EVT-1:0]               evt_sel,
    input  logic [CNT_W-1:0]                 cyc_cnt,
    input  logic [NUM_EVT-2:0][CNT_W-1:0]    nar_cnt,
    input  logic [WIDE_W-1:0]                wide_cnt
);
    logic [DATA_W-1:0] rd_val;
    logic              hit;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:MASK_W];

    // Control: run holds, reset bits live for one cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (reg_we && reg_addr == A_CTRL) begin
            ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        end else begin
            ctrl.evt_clr <= 1'b0;
            ctrl.cyc_clr <= 1'b0;
        end
    end

    // Enable mask through set / clear ports
    always_ff @(posedge clk) begin
        if (rst) begin
            en_mask <= '0;
        end else if (reg_we && reg_addr == A_EN_SET) begin
            en_mask <= en_mask | reg_wdata[MASK_W-1:0];
        end else if (reg_we && reg_addr == A_EN_CLR) begin
            en_mask <= en_mask & ~reg_wdata[MASK_W-1:0];
        end
    end

    // Per-counter event selects
    for (genvar g = 0; g < NUM_EVT; g++) begin : g_sel
        localparam logic [ADDR_W-1:0] SEL_ADDR = A_SEL_BASE + ADDR_W'(4 * g);
        always_ff @(posedge clk) begin
            if (rst) begin
                evt_sel[g] <= '0;
            end else if (reg_we && reg_addr == SEL_ADDR) begin
                evt_sel[g] <= reg_wdata[SEL_W-1:0];
            end
        end
    end

    // Read decode
    always_comb begin
        rd_val = '0;
        hit    = 1'b0;
        if (reg_addr == A_CTRL) begin
            rd_val = DATA_W'(ctrl);
            hit    = 1'b1;
        end
        if (reg_addr == A_EN_SET || reg_addr == A_EN_CLR) begin
            rd_val = DATA_W'(en_mask);
            hit    = 1'b1;
        end
        for (int i = 0; i < NUM_EVT; i++) begin
            if (reg_addr == A_SEL_BASE + ADDR_W'(4 * i)) begin
                rd_val = DATA_W'(evt_sel[i]);
                hit    = 1'b1;
            end
        end
        if (reg_addr == A_CYC) begin
            rd_val = cyc_cnt;
            hit    = 1'b1;
        end
        for (int i = 0; i < NUM_EVT - 1; i++) begin
            if (reg_addr == A_CNT_BASE + ADDR_W'(4 * i)) begin
                rd_val = nar_cnt[i];
                hit    = 1'b1;
            end
        end
        if (reg_addr == A_WIDE_LO) begin
            rd_val = DATA_W'(wide_cnt[LO_W-1:0]);
            hit    = 1'b1;
        end
        if (reg_addr == A_WIDE_HI) begin
            rd_val = DATA_W'(wide_cnt[WIDE_W-1:LO_W]);
            hit    = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            reg_rdata <= '0;
        end else if (reg_re) begin
            reg_rdata <= rd_val;
        end
    end

    AST_RESET_PULSE: assert property (@(posedge clk) disable iff (rst)
        (ctrl.evt_clr || ctrl.cyc_clr) && !reg_we |=> !ctrl.evt_clr && !ctrl.cyc_clr); // R6

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_EN_SET) |=>
            (en_mask & $past(reg_wdata[MASK_W-1:0])) == $past(reg_wdata[MASK_W-1:0])); // R2

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == A_EN_CLR) |=>
            (en_mask & $past(reg_wdata[MASK_W-1:0])) == '0); // R2

    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_re && !hit) |=> reg_rdata == '0); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
        !reg_re |=> $stable(reg_rdata)); // R9
endmodule

// File: rtl/bus_perf_monitor.sv
module bus_perf_monitor
    import bpm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic              reg_re,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              rd_beat,
    input  logic              wr_beat
);
    ctrl_t                          ctrl;
    logic [MASK_W-1:0]              en_mask;
    sel_t [NUM_EVT-1:0]             evt_sel;
    logic [CNT_W-1:0]               cyc_cnt;
    logic [NUM_EVT-2:0][CNT_W-1:0]  nar_cnt;
    logic [WIDE_W-1:0]              wide_cnt;

    bpm_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctrl      (ctrl),
        .en_mask   (en_mask),
        .evt_sel   (evt_sel),
        .cyc_cnt   (cyc_cnt),
        .nar_cnt   (nar_cnt),
        .wide_cnt  (wide_cnt)
    );

    bpm_counter #(.W(CNT_W)) u_cyc (
        .clk  (clk),
        .rst  (rst),
        .clr  (ctrl.cyc_clr),
        .run  (ctrl.run && en_mask[CYC_BIT]),
        .step (2'd1),
        .cnt  (cyc_cnt)
    );

    for (genvar g = 0; g < NUM_EVT; g++) begin : g_evt
        logic [1:0] step;
        logic       run;
        assign step = evt_step(evt_sel[g], rd_beat, wr_beat);
        assign run  = ctrl.run && en_mask[g];
        if (g == NUM_EVT - 1) begin : g_wide
            bpm_counter #(.W(WIDE_W)) u_cnt (
                .clk  (clk),
                .rst  (rst),
                .clr  (ctrl.evt_clr),
                .run  (run),
                .step (step),
                .cnt  (wide_cnt)
            );
        end else begin : g_nar
            bpm_counter #(.W(CNT_W)) u_cnt (
                .clk  (clk),
                .rst  (rst),
                .clr  (ctrl.evt_clr),
                .run  (run),
                .step (step),
                .cnt  (nar_cnt[g])
            );
        end
    end

    AST_CYC_ADVANCE: assert property (@(posedge clk) disable iff (rst)
        (ctrl.run && en_mask[CYC_BIT] && !ctrl.cyc_clr) |=>
            cyc_cnt == $past(cyc_cnt) + 32'd1); // R3

    AST_FROZEN_CYC: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !ctrl.cyc_clr) |=> $stable(cyc_cnt)); // R5

    AST_FROZEN_WIDE: assert property (@(posedge clk) disable iff (rst)
        (!ctrl.run && !ctrl.evt_clr) |=> $stable(wide_cnt)); // R5
endmodule

// File: tb/bus_perf_monitor_test.sv
`timescale 1ns/1ps
module bus_perf_monitor_test;
    logic        clk = 1'b0;
    logic        rst;
    logic        reg_we;
    logic        reg_re;
    logic [7:0]  reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        rd_beat;
    logic        wr_beat;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    bus_perf_monitor uut (
        .clk       (clk),
        .rst       (rst),
        .reg_we    (reg_we),
        .reg_re    (reg_re),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .rd_beat   (rd_beat),
        .wr_beat   (wr_beat)
    );

    localparam logic [7:0] CTRL = 8'h00, ENSET = 8'h04, ENCLR = 8'h08;
    localparam logic [7:0] SEL0 = 8'h10, SEL1 = 8'h14, SEL2 = 8'h18, SEL3 = 8'h1C;
    localparam logic [7:0] CYC = 8'h20, CNT0 = 8'h24, CNT1 = 8'h28, CNT2 = 8'h2C;
    localparam logic [7:0] WLO = 8'h30, WHI = 8'h34, HOLE = 8'h3C;

    // Driver tasks: called just after a falling edge
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_re = 1'b1; reg_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        reg_re = 1'b0;
    endtask

    // Monitor: compares the registered read data after the sampling edge
    initial begin
        forever begin
            @(posedge clk);
            if (reg_re && !rst) begin
                #2;
                if (exp_q.size() == 0) begin
                    errors++; checks++;
                    $display("FAIL scoreboard: read with no expected item, actual=%h", reg_rdata);
                end else begin
                    logic [31:0] e;
                    string t;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    checks++;
                    if (reg_rdata !== e) begin
                        errors++;
                        $display("FAIL %s: actual=%h expected=%h", t, reg_rdata, e);
                    end
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1; reg_we = 1'b0; reg_re = 1'b0; reg_addr = '0; reg_wdata = '0;
        rd_beat = 1'b0; wr_beat = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(CTRL,  32'h0, "R1 ctrl");
        rd(ENSET, 32'h0, "R1 mask");
        rd(SEL0,  32'h0, "R1 sel0");
        rd(SEL3,  32'h0, "R1 sel3");
        rd(CYC,   32'h0, "R1 cycle");
        rd(CNT0,  32'h0, "R1 cnt0");
        rd(WLO,   32'h0, "R1 wide lo");
        rd(WHI,   32'h0, "R1 wide hi");

        // R2 set / clear semantics, R9 back-to-back reads
        wr(ENSET, 32'h01);
        rd(ENSET, 32'h01, "R2 set bit0");
        wr(ENSET, 32'h04);
        rd(ENCLR, 32'h05, "R2 set keeps other bits");
        wr(ENCLR, 32'h01);
        rd(ENSET, 32'h04, "R2 clear bit0");
        wr(ENCLR, 32'h00);
        rd(ENSET, 32'h04, "R2 zero clear no effect");
        wr(ENCLR, 32'h1F);
        rd(ENSET, 32'h00, "R2 clear all");

        // R8 unmapped address
        wr(HOLE, 32'hFFFF_FFFF);
        rd(ENSET, 32'h00, "R8 write ignored mask");
        rd(CTRL,  32'h00, "R8 write ignored ctrl");
        rd(HOLE,  32'h00, "R8 read zero");

        // R4 selects and mixed traffic, R3 cycle count
        wr(SEL0, 32'h1);
        wr(SEL1, 32'h2);
        wr(SEL2, 32'h3);
        wr(SEL3, 32'h3);
        rd(SEL1, 32'h2, "R4 select readback");
        wr(ENSET, 32'h17);
        wr(CTRL, 32'h1);
        for (int c = 0; c < 9; c++) begin
            rd_beat = (c < 5);
            wr_beat = (c >= 3);
            @(negedge clk);
        end
        rd_beat = 1'b0; wr_beat = 1'b0;
        wr(CTRL, 32'h0);
        rd(CYC,  32'd10, "R3 cycle window");
        rd(CNT0, 32'd5,  "R4 read beats");
        rd(CNT1, 32'd6,  "R4 write beats");
        rd(CNT2, 32'd11, "R4 both adds two");
        rd(WLO,  32'd0,  "R4 disabled counter");
        rd(CTRL, 32'h0,  "R4 ctrl after stop");

        // R5 frozen while run clear
        rd_beat = 1'b1; wr_beat = 1'b1;
        repeat (6) @(negedge clk);
        rd_beat = 1'b0; wr_beat = 1'b0;
        rd(CYC,  32'd10, "R5 cycle frozen");
        rd(CNT0, 32'd5,  "R5 cnt0 frozen");
        rd(CNT2, 32'd11, "R5 cnt2 frozen");

        // R6 cycle reset alone
        wr(CTRL, 32'h4);
        rd(CTRL, 32'h4, "R6 reset bit visible one cycle");
        rd(CTRL, 32'h0, "R6 reset bit self clears");
        rd(CYC,  32'd0, "R6 cycle zeroed");
        rd(CNT0, 32'd5, "R6 events untouched by cycle reset");

        // R6 event reset wins over increment
        rd_beat = 1'b1; wr_beat = 1'b1;
        wr(CTRL, 32'h3);
        wr(CTRL, 32'h0);
        rd_beat = 1'b0; wr_beat = 1'b0;
        rd(CNT0, 32'd0, "R6 cnt0 reset priority");
        rd(CNT2, 32'd0, "R6 cnt2 reset priority");
        rd(CYC,  32'd1, "R6 cycle untouched by event reset");

        // R7 wide counter split readout
        wr(ENCLR, 32'h1F);
        wr(ENSET, 32'h08);
        rd_beat = 1'b1; wr_beat = 1'b1;
        wr(CTRL, 32'h1);
        repeat (299) @(negedge clk);
        wr(CTRL, 32'h0);
        rd_beat = 1'b0; wr_beat = 1'b0;
        rd(WLO,  32'h58, "R7 wide low byte");
        rd(WHI,  32'h02, "R7 wide high part");
        rd(CNT0, 32'd0,  "R7 cnt0 stays off");
        rd(CYC,  32'd1,  "R3 cycle holds when mask bit clear");

        repeat (3) @(negedge clk);
        if (exp_q.size() != 0) begin
            errors++; checks++;
            $display("FAIL scoreboard: actual=%0d pending expected=0", exp_q.size());
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule